// File: doc/BRIEF.md
# Unpacked BCD adjust unit

This block corrects a 16-bit accumulator, split into a high byte and a low byte, after or before arithmetic on unpacked decimal digits. It has four operations. Two apply a nibble correction after a binary add or subtract. One splits a binary byte into two decimal digits after a multiply. One folds two decimal digits into a single binary byte before a divide. Each operation also produces a carry flag and an auxiliary-carry flag. The multiply and divide operations also produce parity, sign and zero flags taken from the result low byte.

A caller presents the operation code, the accumulator and the incoming auxiliary-carry and carry flags, then raises `start` for one cycle. The result and the flags are registered, and `valid` pulses for one cycle when they land. The split after multiply divides by ten. With the default parameter it does this one quotient bit per cycle, and `busy` stays high while it runs. A `start` that arrives while `busy` is high is dropped.

The operation codes on `op` are: 0 = add adjust, 1 = subtract adjust, 2 = multiply adjust, 3 = divide adjust. Below, AH means `ax_in[15:8]` and AL means `ax_in[7:0]`.

Top module: `bcd_adjust_unit`

## Requirements
- R1: With op = 0, when AL[3:0] > 9 or `af_in` = 1, the result low byte is (AL + 6) with bits 7..4 forced to zero, the result high byte is AH + 1 modulo 256, and `af_out` = `cf_out` = 1.
- R2: With op = 0 and the R1 condition false, the result high byte equals AH, the result low byte is AL with bits 7..4 forced to zero, and `af_out` = `cf_out` = 0.
- R3: With op = 1, when AL[3:0] > 9 or `af_in` = 1, the result low byte is (AL - 6) with bits 7..4 forced to zero, the result high byte is AH - 1 modulo 256, and `af_out` = `cf_out` = 1.
- R4: With op = 1 and the R3 condition false, the result high byte equals AH, the result low byte is AL with bits 7..4 cleared, and `af_out` = `cf_out` = 0.
- R5: With op = 2, the result high byte is AL / 10 and the result low byte is AL mod 10 (AL = 23h gives 0305h). `af_out` and `cf_out` take the `af_in` and `cf_in` values sampled with the accepted `start`.
- R6: With op = 3, the result low byte is (AH*10 + AL) mod 256 and the result high byte is 0. `af_out` and `cf_out` take `af_in` and `cf_in`.
- R7: After op 2 or 3, `pf_out` = 1 exactly when the result low byte has an even number of one bits, `sf_out` = bit 7 of the result low byte, and `zf_out` = 1 exactly when the result low byte is zero. Ops 0 and 1 leave these three flags unchanged.
- R8: Take a `start` sampled at clock edge E0 while `busy` = 0. For ops 0, 1 and 3, the outputs update and `valid` = 1 after E0. For op 2, `busy` = 1 from E0 until E8, and the outputs update with `valid` = 1 after E8. `valid` is high for exactly one cycle per result and is never high together with `busy`.
- R9: A `start` sampled while `busy` = 1 is ignored. It produces no `valid` pulse, and the outputs keep their values until the running operation completes with its own result.
- R10: After synchronous reset, `ax_out` = 0, all five flag outputs are 0, and `busy` = `valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| op | input | 2 | Operation code: 0 add, 1 subtract, 2 multiply, 3 divide adjust |
| ax_in | input | 16 | Accumulator, high byte then low byte |
| af_in | input | 1 | Incoming auxiliary-carry flag |
| cf_in | input | 1 | Incoming carry flag |
| ax_out | output | 16 | Registered adjusted accumulator |
| af_out | output | 1 | Registered auxiliary-carry flag |
| cf_out | output | 1 | Registered carry flag |
| pf_out | output | 1 | Registered parity flag (even count of ones) |
| sf_out | output | 1 | Registered sign flag |
| zf_out | output | 1 | Registered zero flag |
| busy | output | 1 | Iterative divide by ten in progress |
| valid | output | 1 | One-cycle pulse when a new result is on the outputs |

## Verification
Most internal faults show up on the very next `valid` pulse. A wrong nibble test or correction constant gives a wrong low digit or a wrong flag one cycle after `start`. A step counter that is off by one or a misaligned shift in the divide-by-ten gives either a quotient with one bit too many or too few, or a `valid` that arrives on the wrong cycle, which is visible within nine cycles. A flag hold path that is lost shows as parity, sign or zero flags changing after an add or subtract adjust. A fault in the busy guard shows as an extra `valid` or an overwritten result right after the ignored `start`.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;

  typedef enum logic [1:0] {
    OP_ADD_ADJ = 2'd0,
    OP_SUB_ADJ = 2'd1,
    OP_MUL_ADJ = 2'd2,
    OP_DIV_ADJ = 2'd3
  } adj_op_e;

  localparam int unsigned DEC_BASE  = 10;
  localparam int unsigned NIB_LIMIT = 9;
  localparam int unsigned DEC_FIX   = 6;

endpackage

// File: rtl/bcd_nibble_fix.sv
// Add/subtract digit correction: decides whether the low digit overflowed
// and applies the +/-6 correction with the matching high-byte carry.
module bcd_nibble_fix #(
  parameter int BYTE_W = 8
) (
  input  logic                  sub_i,
  input  logic [2*BYTE_W-1:0]   ax_i,
  input  logic                  af_i,
  output logic [2*BYTE_W-1:0]   ax_o,
  output logic                  fix_o
);
  import bcd_adj_pkg::*;

  localparam int NIB_W = BYTE_W / 2;

  logic [BYTE_W-1:0] lo_b, hi_b, lo_f, hi_f;

  assign lo_b  = ax_i[BYTE_W-1:0];
  assign hi_b  = ax_i[2*BYTE_W-1:BYTE_W];
  assign fix_o = (lo_b[NIB_W-1:0] > NIB_W'(NIB_LIMIT)) || af_i;

  always_comb begin
    lo_f = lo_b;
    hi_f = hi_b;
    if (fix_o) begin
      if (sub_i) begin
        lo_f = lo_b - BYTE_W'(DEC_FIX);
        hi_f = hi_b - BYTE_W'(1);
      end else begin
        lo_f = lo_b + BYTE_W'(DEC_FIX);
        hi_f = hi_b + BYTE_W'(1);
      end
    end
  end

  assign ax_o = {hi_f, {NIB_W{1'b0}}, lo_f[NIB_W-1:0]};

endmodule

// File: rtl/bcd_div_seq.sv
// Restoring divider by a constant: one quotient bit per cycle.
// quo_o/rem_o carry the next-state values, final when last_o is high.
module bcd_div_seq #(
  parameter int W       = 8,
  parameter int DIVISOR = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] dividend_i,
  output logic         busy_o,
  output logic         last_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  localparam int RW = $clog2(DIVISOR);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  quo_q, quo_n;
  logic [RW-1:0] rem_q, rem_n;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic [RW:0]   trial;
  logic          ge;

  assign trial = {rem_q, quo_q[W-1]};
  assign ge    = trial >= (RW+1)'(DIVISOR);
  assign rem_n = ge ? RW'(trial - (RW+1)'(DIVISOR)) : trial[RW-1:0];
  assign quo_n = {quo_q[W-2:0], ge};

  always_ff @(posedge clk) begin
    if (rst) begin
      quo_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      quo_q  <= dividend_i;
      rem_q  <= '0;
      cnt_q  <= CW'(W);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      quo_q <= quo_n;
      rem_q <= rem_n;
      cnt_q <= cnt_q - CW'(1);
      if (cnt_q == CW'(1)) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign last_o = busy_q && (cnt_q == CW'(1));
  assign quo_o  = quo_n;
  assign rem_o  = W'(rem_n);

endmodule

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit #(
  parameter int BYTE_W   = 8,
  parameter bit ITER_DIV = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [1:0]          op,
  input  logic [2*BYTE_W-1:0] ax_in,
  input  logic                af_in,
  input  logic                cf_in,
  output logic [2*BYTE_W-1:0] ax_out,
  output logic                af_out,
  output logic                cf_out,
  output logic                pf_out,
  output logic                sf_out,
  output logic                zf_out,
  output logic                busy,
  output logic                valid
);
  import bcd_adj_pkg::*;

  localparam int AX_W = 2 * BYTE_W;

  logic              accept;
  logic [BYTE_W-1:0] lo_in, hi_in, fold_val;
  logic [AX_W-1:0]   nib_ax;
  logic              nib_fix;
  logic [BYTE_W-1:0] mul_q, mul_r;
  logic              mul_done, div_busy;
  logic              pend_af, pend_cf;

  logic [AX_W-1:0]   res_ax;
  logic              res_af, res_cf, res_upd, res_fire;
  logic [BYTE_W-1:0] res_lo;

  assign lo_in    = ax_in[BYTE_W-1:0];
  assign hi_in    = ax_in[AX_W-1:BYTE_W];
  assign accept   = start && !div_busy;
  assign fold_val = BYTE_W'(hi_in * BYTE_W'(DEC_BASE)) + lo_in;

  bcd_nibble_fix #(.BYTE_W(BYTE_W)) u_nib (
    .sub_i (op == OP_SUB_ADJ),
    .ax_i  (ax_in),
    .af_i  (af_in),
    .ax_o  (nib_ax),
    .fix_o (nib_fix)
  );

  generate
    if (ITER_DIV) begin : g_iter
      bcd_div_seq #(.W(BYTE_W), .DIVISOR(DEC_BASE)) u_div (
        .clk        (clk),
        .rst        (rst),
        .load_i     (accept && (op == OP_MUL_ADJ)),
        .dividend_i (lo_in),
        .busy_o     (div_busy),
        .last_o     (mul_done),
        .quo_o      (mul_q),
        .rem_o      (mul_r)
      );
    end else begin : g_flat
      assign div_busy = 1'b0;
      assign mul_done = 1'b0;
      assign mul_q    = lo_in / BYTE_W'(DEC_BASE);
      assign mul_r    = lo_in % BYTE_W'(DEC_BASE);
    end
  endgenerate

  // Incoming flags held for the iterative multiply adjust
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_af <= 1'b0;
      pend_cf <= 1'b0;
    end else if (accept) begin
      pend_af <= af_in;
      pend_cf <= cf_in;
    end
  end

  always_comb begin
    res_ax   = '0;
    res_af   = 1'b0;
    res_cf   = 1'b0;
    res_upd  = 1'b0;
    res_fire = 1'b0;
    if (mul_done) begin
      res_ax   = {mul_q, mul_r};
      res_af   = pend_af;
      res_cf   = pend_cf;
      res_upd  = 1'b1;
      res_fire = 1'b1;
    end else if (accept) begin
      case (adj_op_e'(op))
        OP_ADD_ADJ, OP_SUB_ADJ: begin
          res_ax   = nib_ax;
          res_af   = nib_fix;
          res_cf   = nib_fix;
          res_fire = 1'b1;
        end
        OP_DIV_ADJ: begin
          res_ax   = {{BYTE_W{1'b0}}, fold_val};
          res_af   = af_in;
          res_cf   = cf_in;
          res_upd  = 1'b1;
          res_fire = 1'b1;
        end
        default: begin
          res_ax   = {mul_q, mul_r};
          res_af   = af_in;
          res_cf   = cf_in;
          res_upd  = !ITER_DIV;
          res_fire = !ITER_DIV;
        end
      endcase
    end
  end

  assign res_lo = res_ax[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ax_out <= '0;
      af_out <= 1'b0;
      cf_out <= 1'b0;
      pf_out <= 1'b0;
      sf_out <= 1'b0;
      zf_out <= 1'b0;
      valid  <= 1'b0;
    end else begin
      valid <= res_fire;
      if (res_fire) begin
        ax_out <= res_ax;
        af_out <= res_af;
        cf_out <= res_cf;
      end
      if (res_fire && res_upd) begin
        pf_out <= ~^res_lo;
        sf_out <= res_lo[BYTE_W-1];
        zf_out <= (res_lo == '0);
      end
    end
  end

  assign busy = div_busy;

endmodule

// File: rtl/bcd_adjust_unit_chk.sv
module bcd_adjust_unit_chk #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic [1:0]          op,
  input logic [2*BYTE_W-1:0] ax_out,
  input logic                af_out,
  input logic                cf_out,
  input logic                zf_out,
  input logic                busy,
  input logic                valid
);
  logic [1:0] trk_op;

  always_ff @(posedge clk) begin
    if (rst) trk_op <= 2'd0;
    else if (start && !busy) trk_op <= op;
  end

  assert_fast_valid_R8: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && op != 2'd2) |=> valid);

  assert_busy_excl_R8: assert property (@(posedge clk) disable iff (rst)
    busy |-> !valid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(ax_out) |-> valid);

  assert_addsub_shape_R2: assert property (@(posedge clk) disable iff (rst)
    (valid && !trk_op[1]) |->
      (ax_out[BYTE_W-1:BYTE_W/2] == '0) && (af_out == cf_out));

  assert_mul_rem_R5: assert property (@(posedge clk) disable iff (rst)
    (valid && trk_op == 2'd2) |-> (ax_out[BYTE_W-1:0] < BYTE_W'(10)));

  assert_div_high_R6: assert property (@(posedge clk) disable iff (rst)
    (valid && trk_op == 2'd3) |-> (ax_out[2*BYTE_W-1:BYTE_W] == '0));

  assert_zero_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (valid && trk_op[1]) |-> (zf_out == (ax_out[BYTE_W-1:0] == '0)));

endmodule

bind bcd_adjust_unit bcd_adjust_unit_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .op     (op),
  .ax_out (ax_out),
  .af_out (af_out),
  .cf_out (cf_out),
  .zf_out (zf_out),
  .busy   (busy),
  .valid  (valid)
);

// File: tb/tb_bcd_adjust_unit.sv
`timescale 1ns/1ps
module tb_bcd_adjust_unit;
  localparam real CLK_NS = 20.0;
  localparam int  NVEC   = 14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [15:0] ax_in = '0;
  logic        af_in = 1'b0, cf_in = 1'b0;
  logic [15:0] ax_out;
  logic        af_out, cf_out, pf_out, sf_out, zf_out, busy, valid;

  int errors = 0;
  int checks = 0;
  logic [2:0] m_psz = 3'b000;

  always #(CLK_NS/2) clk = ~clk;

  bcd_adjust_unit dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .ax_in(ax_in),
    .af_in(af_in), .cf_in(cf_in), .ax_out(ax_out), .af_out(af_out),
    .cf_out(cf_out), .pf_out(pf_out), .sf_out(sf_out), .zf_out(zf_out),
    .busy(busy), .valid(valid)
  );

  // {op, ax, af, cf, expected ax, expected af, expected cf}
  localparam logic [37:0] VEC [NVEC] = '{
    {2'd0, 16'h000B, 1'b0, 1'b0, 16'h0101, 1'b1, 1'b1},
    {2'd0, 16'h0234, 1'b0, 1'b0, 16'h0204, 1'b0, 1'b0},
    {2'd0, 16'h0532, 1'b1, 1'b0, 16'h0608, 1'b1, 1'b1},
    {2'd0, 16'hFF0F, 1'b0, 1'b0, 16'h0005, 1'b1, 1'b1},
    {2'd1, 16'h03FF, 1'b0, 1'b0, 16'h0209, 1'b1, 1'b1},
    {2'd1, 16'h0104, 1'b1, 1'b0, 16'h000E, 1'b1, 1'b1},
    {2'd1, 16'h0739, 1'b0, 1'b1, 16'h0709, 1'b0, 1'b0},
    {2'd2, 16'h0023, 1'b1, 1'b0, 16'h0305, 1'b1, 1'b0},
    {2'd2, 16'h00FF, 1'b0, 1'b1, 16'h1905, 1'b0, 1'b1},
    {2'd2, 16'hAB00, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0},
    {2'd3, 16'h0305, 1'b0, 1'b0, 16'h0023, 1'b0, 1'b0},
    {2'd3, 16'h1907, 1'b1, 1'b1, 16'h0001, 1'b1, 1'b1},
    {2'd3, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0},
    {2'd3, 16'h0908, 1'b0, 1'b1, 16'h0062, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] psz_of(input logic [7:0] v);
    return {~^v, v[7], v == 8'h00};
  endfunction

  function automatic string tag_of(input logic [1:0] o, input logic fixed);
    case (o)
      2'd0: return fixed ? "R1" : "R2";
      2'd1: return fixed ? "R3" : "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic run_op(input logic [1:0] o, input logic [15:0] a, input logic fa,
                        input logic fc, input logic [15:0] ea, input logic efa,
                        input logic efc);
    int k;
    @(negedge clk);
    start = 1'b1; op = o; ax_in = a; af_in = fa; cf_in = fc;
    k = 0;
    do begin
      @(negedge clk);
      k++;
      start = 1'b0;
      if (k == 1 && o == 2'd2) chk("R8 busy during multiply adjust", 32'(busy), 32'd1);
    end while (!valid && k < 20);
    chk("R8 latency", k, (o == 2'd2) ? 9 : 1);
    chk(tag_of(o, efa), 32'(ax_out), 32'(ea));
    chk(tag_of(o, efa), {af_out, cf_out}, {efa, efc});
    if (o[1]) m_psz = psz_of(ea[7:0]);
    chk("R7 parity/sign/zero", {pf_out, sf_out, zf_out}, 32'(m_psz));
    @(negedge clk);
    chk("R8 single-cycle valid", 32'(valid), 32'd0);
  endtask

  initial begin
    #(CLK_NS * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 ax", 32'(ax_out), 32'd0);
    chk("R10 flags", {af_out, cf_out, pf_out, sf_out, zf_out}, 32'd0);
    chk("R10 busy/valid", {busy, valid}, 32'd0);

    for (int i = 0; i < NVEC; i++)
      run_op(VEC[i][37:36], VEC[i][35:20], VEC[i][19], VEC[i][18],
             VEC[i][17:2], VEC[i][1], VEC[i][0]);

    // R9: start during a running multiply adjust is ignored
    begin
      int k;
      @(negedge clk);
      start = 1'b1; op = 2'd2; ax_in = 16'h0063; af_in = 1'b1; cf_in = 1'b1;
      k = 0;
      do begin
        @(negedge clk);
        k++;
        start = 1'b0;
        if (k == 3) begin
          start = 1'b1; op = 2'd0; ax_in = 16'h000F; af_in = 1'b0; cf_in = 1'b0;
        end
        if (k >= 2 && k < 9 && !valid) chk("R9 output held while busy", 32'(ax_out), 32'h0062);
      end while (!valid && k < 20);
      chk("R9 latency unaffected", k, 9);
      chk("R9 result of running op", 32'(ax_out), 32'h0909);
      chk("R9 flags of running op", {af_out, cf_out}, 2'b11);
      chk("R7 parity after multiply adjust", {pf_out, sf_out, zf_out}, 32'(psz_of(8'h09)));
      @(negedge clk);
      chk("R9 no extra valid", 32'(valid), 32'd0);
      chk("R9 result kept", 32'(ax_out), 32'h0909);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule